// File: doc/BRIEF.md
# Banked EEPROM Window Mapper

This block sits between a byte-wide register port and two storage targets: the on-chip configuration registers and an external serial EEPROM. The host sees 128 byte addresses. The upper half, 0x40 to 0x7F, always reaches the on-chip registers. The lower half, 0x00 to 0x3F, is a 64-byte window. A bank-select register chooses which 64-byte bank of the EEPROM's linear space appears in that window. Bank 0 is special: it shows the on-chip registers instead of EEPROM contents, and it is the bank selected after reset.

A 2-bit size code gives the EEPROM capacity and divides it into three regions. The configuration region covers banks 0 and 1. A data-sheet region follows it, and a free user region follows that. The block computes the target and its address for every access without any cycle of delay. It tags each access with its region, blocks writes to a write-protected region, and reports a blocked write on a one-cycle error flag. An access to a bank beyond the configured capacity is out of range: a read returns all ones and a write is dropped.

Top module: `eeprom_window_mapper`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the bank select is 0 and the size code is 00. A read of 0x40 returns 0x00, and a read of 0x26 returns 00 in bits 7:6.
- R2: Any access to 0x40–0x7F goes to the internal registers whatever the bank select: tgt_sel = 01, region = 0 (internal), tgt_addr = bus_addr zero-extended.
- R3: With bank 0 selected, an access to 0x00–0x3F goes to the internal registers (tgt_sel = 01) at tgt_addr = bus_addr, with region = 1 (configuration).
- R4: With an in-range bank b ≠ 0 selected, an access to 0x00–0x3F goes to the EEPROM (tgt_sel = 10) at linear address b·64 + bus_addr[5:0]. The bank number lies in tgt_addr[10:6].
- R5: A granted write to 0x40 loads wr_data[4:0] into the bank select at the clock edge that samples it. Bits 7:5 are ignored. Reads of 0x40 return the bank in bits 4:0 with zeros above.
- R6: A granted write to 0x26 while bank 0 is selected loads wr_data[7:6] into the size code. With another bank selected, the write goes to the EEPROM and the size code is unchanged. Reads of 0x26 with bank 0 return the size code in bits 7:6 and int_rd_data[5:0] below.
- R7: The region encoding is 1 configuration, 2 data sheet, 3 user, 4 out of range. Banks 0–1 are configuration. The data sheet then takes 1/2/2/6 banks and the user region takes 1/4/12/24 banks, for size codes 00/01/10/11. The total is 4/8/16/32 banks.
- R8: A bank at or above the configured total is out of range: region = 4, tgt_sel = 00, rd_data = 0xFF, wr_grant = 0.
- R9: A write is denied (wr_grant = 0) in two cases: it hits the configuration region while prot_conf = 1, or it hits the data-sheet region while prot_eds = 1. Writes to the user region and to 0x40–0x7F are always granted.
- R10: wr_err is 1 in the cycle after a write was denied by protection, and 0 after any other cycle.
- R11: Without rd_en or wr_en, tgt_sel = 00 and wr_grant = 0.
- R12: Read data comes from eep_rd_data for an EEPROM target and from int_rd_data for an internal target, except for the register fields of R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 7 | Host byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Host write data |
| prot_conf | input | 1 | Write-protect enable for the configuration region |
| prot_eds | input | 1 | Write-protect enable for the data-sheet region |
| int_rd_data | input | 8 | Read data from the internal registers |
| eep_rd_data | input | 8 | Read data from the EEPROM buffer |
| tgt_addr | output | 11 | Internal register address or EEPROM linear address |
| tgt_sel | output | 2 | Target: 00 none, 01 internal, 10 EEPROM |
| region | output | 3 | Region tag: 0 internal, 1 config, 2 data sheet, 3 user, 4 out of range |
| wr_grant | output | 1 | The current write may proceed |
| wr_err | output | 1 | A protected write was refused in the previous cycle |
| rd_data | output | 8 | Host read data |

## Verification
The only state is the bank select, the size code and the error flag, and each one shows at the ports one cycle after the write that changed it. A wrong bank select shows on the next window access as a wrong tgt_addr[10:6], or as a wrong readback of 0x40. A wrong size code shows as a wrong region tag, a wrong out-of-range decision, or a wrong readback of 0x26 on the next access. The vector table sets bank and size through the host port and then checks target, region, address and grant for every region boundary under all four size codes. Directed tests cover the ignored bits and writes that must not change state.

// File: rtl/mapper_pkg.sv
// Package: shared encodings and the bank-partition rule for the window mapper.
// Assumes the configuration region is a fixed number of leading banks.
package mapper_pkg;

    typedef enum logic [1:0] {
        TS_NONE = 2'd0,
        TS_INT  = 2'd1,
        TS_EEP  = 2'd2
    } tsel_t;

    typedef enum logic [2:0] {
        RG_INT  = 3'd0,
        RG_CONF = 3'd1,
        RG_EDS  = 3'd2,
        RG_USER = 3'd3,
        RG_OOR  = 3'd4
    } region_t;

    // Number of data-sheet banks for a size code.
    function automatic int ds_banks(input int code);
        case (code)
            0:       return 1;
            3:       return 6;
            default: return 2;
        endcase
    endfunction

    // Total banks of the EEPROM for a size code (256 bytes doubling).
    function automatic int total_banks(input int code);
        return 4 << code;
    endfunction

    // Region that a bank falls into for a given size code.
    function automatic region_t bank_region(input int bank, input int code,
                                            input int conf_banks);
        if (bank < conf_banks)                        return RG_CONF;
        else if (bank < conf_banks + ds_banks(code))  return RG_EDS;
        else if (bank < total_banks(code))            return RG_USER;
        else                                          return RG_OOR;
    endfunction

endpackage

// File: rtl/win_cfg_regs.sv
// Module: holds the bank select and the size code.
// Assumes wr_grant already accounts for protection and range; the size
// field is writable only while bank 0 maps the window to internal registers.
module win_cfg_regs #(
    parameter int ADDR_W        = 7,
    parameter int DATA_W        = 8,
    parameter int BANK_W        = 5,
    parameter int SIZE_W        = 2,
    parameter logic [ADDR_W-1:0] BANK_REG_ADDR = 7'h40,
    parameter logic [ADDR_W-1:0] SIZE_REG_ADDR = 7'h26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_grant,
    output logic [BANK_W-1:0] bank_q,
    output logic [SIZE_W-1:0] size_q
);
    localparam int SIZE_LSB = DATA_W - SIZE_W;

    logic bank_we;
    logic size_we;
    logic unused_data;

    // Decode which field a granted write lands on.
    always_comb begin
        bank_we = wr_grant && (bus_addr == BANK_REG_ADDR);
        size_we = wr_grant && (bus_addr == SIZE_REG_ADDR) && (bank_q == '0);
    end

    assign unused_data = ^wr_data;

    // Bank select register, bank 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (bank_we) bank_q <= wr_data[BANK_W-1:0];
    end

    // Size code register, smallest size after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       size_q <= '0;
        else if (size_we) size_q <= wr_data[DATA_W-1:SIZE_LSB];
    end

endmodule

// File: rtl/bank_region_lut.sv
// Module: per-bank region table for the current size code, then a bank pick.
// Assumes BANK_W is small enough for one comparator chain per bank.
module bank_region_lut
    import mapper_pkg::*;
#(
    parameter int BANK_W     = 5,
    parameter int SIZE_W     = 2,
    parameter int CONF_BANKS = 2
) (
    input  logic [SIZE_W-1:0] size_q,
    input  logic [BANK_W-1:0] bank,
    output region_t           bank_rg
);
    localparam int NBANKS = 1 << BANK_W;

    region_t rg_vec [NBANKS];

    // One region decode per possible bank.
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign rg_vec[b] = bank_region(b, int'(size_q), CONF_BANKS);
    end

    // Select the entry of the bank in use.
    assign bank_rg = rg_vec[bank];

endmodule

// File: rtl/addr_xlate.sv
// Module: target select, target address, region tag and read-data routing.
// Assumes the top address bit splits the fixed upper half from the window.
module addr_xlate
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int BANK_W = 5,
    parameter int SIZE_W = 2,
    parameter int WIN_W  = 6,
    parameter logic [ADDR_W-1:0] BANK_REG_ADDR = 7'h40,
    parameter logic [ADDR_W-1:0] SIZE_REG_ADDR = 7'h26
) (
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    rd_en,
    input  logic                    wr_en,
    input  logic [BANK_W-1:0]       bank_q,
    input  logic [SIZE_W-1:0]       size_q,
    input  region_t                 bank_rg,
    input  logic [DATA_W-1:0]       int_rd_data,
    input  logic [DATA_W-1:0]       eep_rd_data,
    output logic [BANK_W+WIN_W-1:0] tgt_addr,
    output tsel_t                   tgt_sel,
    output region_t                 region,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int EEP_W    = BANK_W + WIN_W;
    localparam int SIZE_LSB = DATA_W - SIZE_W;

    logic upper;
    logic to_int;

    // Classify the access: fixed half or window, internal or EEPROM.
    always_comb begin
        upper  = bus_addr[ADDR_W-1];
        to_int = upper || (bank_q == '0);
        region = upper ? RG_INT : bank_rg;
    end

    // Target address and target select.
    always_comb begin
        if (to_int) tgt_addr = {{(EEP_W-ADDR_W){1'b0}}, bus_addr};
        else        tgt_addr = {bank_q, bus_addr[WIN_W-1:0]};
        if (!(rd_en || wr_en) || (region == RG_OOR)) tgt_sel = TS_NONE;
        else if (to_int)                             tgt_sel = TS_INT;
        else                                         tgt_sel = TS_EEP;
    end

    // Read data routing with the locally held fields merged in.
    always_comb begin
        if (region == RG_OOR)
            rd_data = '1;
        else if (to_int && (bus_addr == BANK_REG_ADDR))
            rd_data = {{(DATA_W-BANK_W){1'b0}}, bank_q};
        else if (to_int && (bus_addr == SIZE_REG_ADDR))
            rd_data = {size_q, int_rd_data[SIZE_LSB-1:0]};
        else if (to_int)
            rd_data = int_rd_data;
        else
            rd_data = eep_rd_data;
    end

endmodule

// File: rtl/write_guard.sv
// Module: per-region write permission and the registered refusal flag.
// Assumes the region tag is valid in the same cycle as wr_en.
module write_guard
    import mapper_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  region_t region,
    input  logic    prot_conf,
    input  logic    prot_eds,
    output logic    wr_grant,
    output logic    wr_err
);
    logic refused;

    // Decide protection refusal and grant.
    always_comb begin
        refused  = wr_en && (((region == RG_CONF) && prot_conf) ||
                             ((region == RG_EDS)  && prot_eds));
        wr_grant = wr_en && !refused && (region != RG_OOR);
    end

    // One-cycle error pulse after each refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= refused;
    end

endmodule

// File: rtl/eeprom_window_mapper.sv
// Module: top of the banked window mapper. Ties the configuration fields,
// region table, address translation and write guard together.
// Assumes a single-cycle host access with all outputs valid in that cycle.
module eeprom_window_mapper
    import mapper_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 8,
    parameter int BANK_W     = 5,
    parameter int SIZE_W     = 2,
    parameter int WIN_W      = 6,
    parameter int CONF_BANKS = 2,
    parameter logic [ADDR_W-1:0] BANK_REG_ADDR = 7'h40,
    parameter logic [ADDR_W-1:0] SIZE_REG_ADDR = 7'h26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    rd_en,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    prot_conf,
    input  logic                    prot_eds,
    input  logic [DATA_W-1:0]       int_rd_data,
    input  logic [DATA_W-1:0]       eep_rd_data,
    output logic [BANK_W+WIN_W-1:0] tgt_addr,
    output logic [1:0]              tgt_sel,
    output logic [2:0]              region,
    output logic                    wr_grant,
    output logic                    wr_err,
    output logic [DATA_W-1:0]       rd_data
);
    logic [BANK_W-1:0] bank_q;
    logic [SIZE_W-1:0] size_q;
    region_t           bank_rg;
    region_t           region_e;
    tsel_t             tgt_sel_e;

    win_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .SIZE_W(SIZE_W),
        .BANK_REG_ADDR(BANK_REG_ADDR), .SIZE_REG_ADDR(SIZE_REG_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_data(wr_data),
        .wr_grant(wr_grant), .bank_q(bank_q), .size_q(size_q)
    );

    bank_region_lut #(
        .BANK_W(BANK_W), .SIZE_W(SIZE_W), .CONF_BANKS(CONF_BANKS)
    ) u_lut (
        .size_q(size_q), .bank(bank_q), .bank_rg(bank_rg)
    );

    addr_xlate #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .SIZE_W(SIZE_W),
        .WIN_W(WIN_W), .BANK_REG_ADDR(BANK_REG_ADDR), .SIZE_REG_ADDR(SIZE_REG_ADDR)
    ) u_xlate (
        .bus_addr(bus_addr), .rd_en(rd_en), .wr_en(wr_en), .bank_q(bank_q),
        .size_q(size_q), .bank_rg(bank_rg), .int_rd_data(int_rd_data),
        .eep_rd_data(eep_rd_data), .tgt_addr(tgt_addr), .tgt_sel(tgt_sel_e),
        .region(region_e), .rd_data(rd_data)
    );

    write_guard u_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .region(region_e),
        .prot_conf(prot_conf), .prot_eds(prot_eds),
        .wr_grant(wr_grant), .wr_err(wr_err)
    );

    // Present the enum-typed results on plain ports.
    assign tgt_sel = tgt_sel_e;
    assign region  = region_e;

endmodule

// File: rtl/eeprom_window_mapper_chk.sv
// Module: port-level properties of the window mapper, bound to the top.
// Assumes the default encodings of mapper_pkg.
module eeprom_window_mapper_chk
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int EEP_W  = 11,
    parameter int WIN_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [EEP_W-1:0]  tgt_addr,
    input logic [1:0]        tgt_sel,
    input logic [2:0]        region,
    input logic              wr_grant,
    input logic              wr_err,
    input logic [DATA_W-1:0] rd_data
);
    // R2
    upper_half_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) && bus_addr[ADDR_W-1] |->
        (tgt_sel == TS_INT) && (region == RG_INT));

    // R4
    eep_addr_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == TS_EEP) |->
        (tgt_addr[WIN_W-1:0] == bus_addr[WIN_W-1:0]) && (tgt_addr[EEP_W-1:WIN_W] != '0));

    // R8
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_OOR) |-> (rd_data == '1) && !wr_grant && (tgt_sel == TS_NONE));

    // R9
    user_writes_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (region == RG_USER) |-> wr_grant);

    // R10
    refusal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_grant && ((region == RG_CONF) || (region == RG_EDS)) |=> wr_err);

    // R10
    flag_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en) && !$past(wr_grant));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |-> (tgt_sel == TS_NONE) && !wr_grant);

endmodule

bind eeprom_window_mapper eeprom_window_mapper_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EEP_W(BANK_W + WIN_W), .WIN_W(WIN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_en(rd_en), .wr_en(wr_en),
    .tgt_addr(tgt_addr), .tgt_sel(tgt_sel), .region(region),
    .wr_grant(wr_grant), .wr_err(wr_err), .rd_data(rd_data)
);

// File: tb/tb_eeprom_window_mapper.sv
// Bench: vector table over banks and size codes, then directed corner tests.
module tb_eeprom_window_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        prot_conf = 1'b0;
    logic        prot_eds = 1'b0;
    logic [7:0]  int_rd_data = 8'hA5;
    logic [7:0]  eep_rd_data = 8'h3C;
    logic [10:0] tgt_addr;
    logic [1:0]  tgt_sel;
    logic [2:0]  region;
    logic        wr_grant;
    logic        wr_err;
    logic [7:0]  rd_data;

    int checks = 0;
    int failures = 0;

    eeprom_window_mapper dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .prot_conf(prot_conf), .prot_eds(prot_eds),
        .int_rd_data(int_rd_data), .eep_rd_data(eep_rd_data), .tgt_addr(tgt_addr),
        .tgt_sel(tgt_sel), .region(region), .wr_grant(wr_grant), .wr_err(wr_err),
        .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    // Vector: bank, size, addr, wr, prot_conf, prot_eds | sel, region, tgt_addr, grant
    localparam int NV = 20;
    localparam logic [33:0] VECS [NV] = '{
        {5'd0,  2'd0, 7'h10, 1'b0, 1'b0, 1'b0, 2'd1, 3'd1, 11'h010, 1'b0},
        {5'd1,  2'd0, 7'h05, 1'b1, 1'b0, 1'b0, 2'd2, 3'd1, 11'h045, 1'b1},
        {5'd1,  2'd0, 7'h05, 1'b1, 1'b1, 1'b0, 2'd2, 3'd1, 11'h045, 1'b0},
        {5'd2,  2'd0, 7'h3F, 1'b1, 1'b0, 1'b1, 2'd2, 3'd2, 11'h0BF, 1'b0},
        {5'd3,  2'd0, 7'h00, 1'b1, 1'b1, 1'b1, 2'd2, 3'd3, 11'h0C0, 1'b1},
        {5'd4,  2'd0, 7'h00, 1'b0, 1'b0, 1'b0, 2'd0, 3'd4, 11'h100, 1'b0},
        {5'd3,  2'd1, 7'h01, 1'b1, 1'b0, 1'b1, 2'd2, 3'd2, 11'h0C1, 1'b0},
        {5'd4,  2'd1, 7'h02, 1'b1, 1'b1, 1'b1, 2'd2, 3'd3, 11'h102, 1'b1},
        {5'd7,  2'd1, 7'h3F, 1'b0, 1'b0, 1'b0, 2'd2, 3'd3, 11'h1FF, 1'b0},
        {5'd8,  2'd1, 7'h00, 1'b0, 1'b0, 1'b0, 2'd0, 3'd4, 11'h200, 1'b0},
        {5'd3,  2'd2, 7'h00, 1'b0, 1'b0, 1'b0, 2'd2, 3'd2, 11'h0C0, 1'b0},
        {5'd4,  2'd2, 7'h00, 1'b1, 1'b0, 1'b1, 2'd2, 3'd3, 11'h100, 1'b1},
        {5'd15, 2'd2, 7'h3F, 1'b0, 1'b0, 1'b0, 2'd2, 3'd3, 11'h3FF, 1'b0},
        {5'd16, 2'd2, 7'h00, 1'b0, 1'b0, 1'b0, 2'd0, 3'd4, 11'h400, 1'b0},
        {5'd7,  2'd3, 7'h00, 1'b1, 1'b0, 1'b1, 2'd2, 3'd2, 11'h1C0, 1'b0},
        {5'd8,  2'd3, 7'h00, 1'b1, 1'b0, 1'b1, 2'd2, 3'd3, 11'h200, 1'b1},
        {5'd31, 2'd3, 7'h3F, 1'b1, 1'b1, 1'b1, 2'd2, 3'd3, 11'h7FF, 1'b1},
        {5'd5,  2'd0, 7'h45, 1'b1, 1'b1, 1'b1, 2'd1, 3'd0, 11'h045, 1'b1},
        {5'd0,  2'd3, 7'h26, 1'b0, 1'b1, 1'b0, 2'd1, 3'd1, 11'h026, 1'b0},
        {5'd0,  2'd0, 7'h20, 1'b1, 1'b1, 1'b0, 2'd1, 3'd1, 11'h020, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Single write cycle; starts and ends just after a rising edge.
    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        bus_addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Read cycle that checks rd_data before the next edge.
    task automatic rd_expect(input string req, input logic [6:0] a, input logic [7:0] exp);
        bus_addr = a; rd_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        chk(req, {24'd0, rd_data}, {24'd0, exp});
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    // Place bank and size through the host port.
    task automatic setup(input logic [4:0] bank, input logic [1:0] size);
        wr(7'h40, 8'h00);
        wr(7'h26, {size, 6'd0});
        wr(7'h40, {3'd0, bank});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values seen through reads
        rd_expect("R1 bank after reset", 7'h40, 8'h00);
        rd_expect("R1 size after reset", 7'h26, 8'h25);

        // Table walk: R3 target, R7 region, R4 address, R9 grant
        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VECS[i];
            setup(v[33:29], v[28:27]);
            bus_addr = v[26:20]; wr_en = v[19]; rd_en = !v[19];
            prot_conf = v[18]; prot_eds = v[17]; wr_data = '0;
            @(negedge clk);
            chk($sformatf("R3 sel vec%0d", i), {30'd0, tgt_sel}, {30'd0, v[16:15]});
            chk($sformatf("R7 region vec%0d", i), {29'd0, region}, {29'd0, v[14:12]});
            chk($sformatf("R4 addr vec%0d", i), {21'd0, tgt_addr}, {21'd0, v[11:1]});
            chk($sformatf("R9 grant vec%0d", i), {31'd0, wr_grant}, {31'd0, v[0]});
            @(posedge clk); #1;
            wr_en = 1'b0; rd_en = 1'b0; prot_conf = 1'b0; prot_eds = 1'b0;
        end

        // R6: size write with bank 0, readback merges int_rd_data
        setup(5'd0, 2'd3);
        rd_expect("R6 size readback", 7'h26, 8'hE5);

        // R5: upper bits ignored, new bank used on the very next access
        wr(7'h40, 8'hE9);
        rd_expect("R5 bank readback", 7'h40, 8'h09);
        bus_addr = 7'h10; rd_en = 1'b1;
        @(negedge clk);
        chk("R4 bank9 addr", {21'd0, tgt_addr}, 32'h250);
        chk("R12 eeprom data", {24'd0, rd_data}, 32'h3C);
        @(posedge clk); #1; rd_en = 1'b0;

        // R2: upper half unaffected by bank 9
        bus_addr = 7'h7F; rd_en = 1'b1;
        @(negedge clk);
        chk("R2 upper sel", {30'd0, tgt_sel}, 32'd1);
        chk("R12 internal data", {24'd0, rd_data}, 32'hA5);
        @(posedge clk); #1; rd_en = 1'b0;

        // R6: write to 0x26 with bank 9 goes to EEPROM, size stays
        wr(7'h26, 8'h00);
        wr(7'h40, 8'h00);
        rd_expect("R6 size kept", 7'h26, 8'hE5);

        // R9/R10: protected size write refused, flag for one cycle
        prot_conf = 1'b1;
        wr(7'h26, 8'h40);
        prot_conf = 1'b0;
        @(negedge clk);
        chk("R10 flag set", {31'd0, wr_err}, 32'd1);
        @(posedge clk); #1;
        @(negedge clk);
        chk("R10 flag clear", {31'd0, wr_err}, 32'd0);
        rd_expect("R9 size protected", 7'h26, 8'hE5);

        // R8: out-of-range read gives all ones
        setup(5'd4, 2'd0);
        rd_expect("R8 oor data", 7'h00, 8'hFF);

        // R11: idle
        @(negedge clk);
        chk("R11 idle sel", {30'd0, tgt_sel}, 32'd0);
        chk("R11 idle grant", {31'd0, wr_grant}, 32'd0);

        // R1: reset in mid run restores bank 0 and size 00
        setup(5'd9, 2'd2);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        rd_expect("R1 bank after rereset", 7'h40, 8'h00);
        rd_expect("R1 size after rereset", 7'h26, 8'h25);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule